// File: doc/BRIEF.md
# Return-Address Stack with Interrupt Gating

This block keeps the return addresses of a small 8-bit microcontroller core in a dedicated last-in, first-out store of program-counter values. A subroutine call, or the acceptance of an interrupt, saves the current program counter. A return, or a return from interrupt, hands back the most recently saved value on `ret_pc_o` one cycle later. Software cannot read or write the store or its pointer.

The block also decides when an interrupt is accepted. A request that arrives while interrupts are enabled is latched as pending. The block accepts it only when a level is free and no call or return uses the store in that cycle. If the store is full, the request waits until a return frees a level. A call made while the store is full is still carried out. It wraps the write pointer, replaces the oldest address and raises a sticky overflow flag. A return made on an empty store repeats the bottom entry and raises a sticky underflow flag.

Top module: `pc_retstack`

## Requirements
- R1: After a synchronous reset, `ret_pc_o`, `irq_ack_o`, `full_o`, `ovf_o` and `udf_o` are all 0.
- R2: A call saves `pc_i`. Each return presents the saved values in last-in, first-out order on `ret_pc_o`, valid in the cycle after the return strobe.
- R3: An interrupt request made with the enable high is latched. When the store is not full and no call or return is present, `irq_ack_o` is high for one cycle, two cycles after the request strobe. The value saved is `pc_i` from the cycle before the acknowledge is seen.
- R4: An interrupt request made with the enable low is not latched. It never produces an acknowledge, even if the enable is raised later.
- R5: `full_o` is high exactly when all DEPTH (default 16) levels are in use.
- R6: While the store is full, a pending interrupt is held and not acknowledged. The cycle after a return frees a level, the interrupt is accepted, and `irq_ack_o` rises one cycle later.
- R7: A call made while the store is full is still executed. The pointer wraps modulo DEPTH, the oldest entry is overwritten, `full_o` stays high and `ovf_o` becomes 1 and stays 1 until reset.
- R8: A return on an empty store puts the bottom entry (the entry popped last) on `ret_pc_o` again. `udf_o` becomes 1 and stays 1 until reset, and the pointer does not move.
- R9: If a call arrives in the cycle in which a pending interrupt would be accepted, the call is saved first. The interrupt is accepted one cycle later, so its address lies above the call's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_i | input | 1 | Subroutine call strobe (save `pc_i`) |
| ret_i | input | 1 | Return strobe (restore top entry) |
| irq_req_i | input | 1 | Interrupt request strobe |
| irq_en_i | input | 1 | Global interrupt enable |
| pc_i | input | PC_W | Program counter value to save |
| ret_pc_o | output | PC_W | Restored return address |
| irq_ack_o | output | 1 | Interrupt acknowledge pulse |
| full_o | output | 1 | All levels in use |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |

## Verification
A stack pointer that is off by one shows on the first return after a save, because `ret_pc_o` then carries a neighbouring address rather than the value just saved. A wrong level count shows either in `full_o` at the sixteenth save, or as an acknowledge that appears or is withheld when it should not be. A pending latch that is lost or never cleared shows within two cycles: the acknowledge is missing, or a second one follows. The saved interrupt address only comes out on the matching return, so every acceptance is followed by returns that read it back.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PUSH = 2'd1,
    ST_POP  = 2'd2
  } stk_op_e;

  function automatic int unsigned ptr_w(input int unsigned d);
    return (d > 1) ? $clog2(d) : 1;
  endfunction

endpackage

// File: rtl/rstk_ram.sv
module rstk_ram #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned DW    = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst)       rdata_o <= '0;
    else if (re_i) rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
  import rstk_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PW    = 4,
  parameter int unsigned LW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_addr_o,
  output logic          rd_en_o,
  output logic [PW-1:0] rd_addr_o,
  output logic          full_o,
  output logic          ovf_o,
  output logic          udf_o
);

  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);
  localparam logic [PW-1:0] SP_TOP  = PW'(DEPTH - 1);

  stk_op_e       op;
  logic [PW-1:0] sp_q, sp_inc, sp_dec, sp_n;
  logic [LW-1:0] lvl_q, lvl_n;
  logic          ovf_n, udf_n;

  always_comb begin
    if (pop_i)       op = ST_POP;
    else if (push_i) op = ST_PUSH;
    else             op = ST_IDLE;
  end

  assign sp_inc = (sp_q == SP_TOP) ? '0 : sp_q + 1'b1;
  assign sp_dec = (sp_q == '0) ? SP_TOP : sp_q - 1'b1;

  assign wr_en_o   = (op == ST_PUSH);
  assign wr_addr_o = sp_q;
  assign rd_en_o   = (op == ST_POP);
  assign rd_addr_o = (lvl_q == '0) ? sp_q : sp_dec;

  always_comb begin
    sp_n  = sp_q;
    lvl_n = lvl_q;
    ovf_n = ovf_o;
    udf_n = udf_o;
    case (op)
      ST_PUSH: begin
        sp_n = sp_inc;
        if (lvl_q == LVL_MAX) ovf_n = 1'b1;
        else                  lvl_n = lvl_q + 1'b1;
      end
      ST_POP: begin
        if (lvl_q == '0) udf_n = 1'b1;
        else begin
          sp_n  = sp_dec;
          lvl_n = lvl_q - 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q   <= '0;
      lvl_q  <= '0;
      full_o <= 1'b0;
      ovf_o  <= 1'b0;
      udf_o  <= 1'b0;
    end else begin
      sp_q   <= sp_n;
      lvl_q  <= lvl_n;
      full_o <= (lvl_n == LVL_MAX);
      ovf_o  <= ovf_n;
      udf_o  <= udf_n;
    end
  end

  assert_level_bound_R5: assert property (@(posedge clk) disable iff (rst)
    lvl_q <= LVL_MAX);
  assert_full_after_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && lvl_q == LVL_MAX - 1'b1) |=> full_o);
  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> ovf_o);
  assert_udf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    udf_o |=> udf_o);
  assert_empty_pop_holds_R8: assert property (@(posedge clk) disable iff (rst)
    (pop_i && lvl_q == '0) |=> (lvl_q == '0 && udf_o && $stable(sp_q)));

endmodule

// File: rtl/rstk_irq_gate.sv
module rstk_irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic req_i,
  input  logic en_i,
  input  logic call_i,
  input  logic ret_i,
  input  logic full_i,
  output logic take_o,
  output logic ack_o
);

  logic pend_q;

  assign take_o = pend_q & en_i & ~full_i & ~call_i & ~ret_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      ack_o  <= 1'b0;
    end else begin
      pend_q <= (pend_q & ~take_o) | (req_i & en_i);
      ack_o  <= take_o;
    end
  end

  assert_pending_held_full_R6: assert property (@(posedge clk) disable iff (rst)
    (pend_q && full_i) |=> pend_q);
  assert_no_spurious_ack_R4: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !(req_i && en_i)) |=> (!ack_o && !pend_q));

endmodule

// File: rtl/pc_retstack.sv
module pc_retstack #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned PC_W  = 13
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            call_i,
  input  logic            ret_i,
  input  logic            irq_req_i,
  input  logic            irq_en_i,
  input  logic [PC_W-1:0] pc_i,
  output logic [PC_W-1:0] ret_pc_o,
  output logic            irq_ack_o,
  output logic            full_o,
  output logic            ovf_o,
  output logic            udf_o
);

  localparam int unsigned PW = rstk_pkg::ptr_w(DEPTH);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic          take;
  logic          wr_en, rd_en;
  logic [PW-1:0] wr_addr, rd_addr;

  rstk_irq_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .req_i  (irq_req_i),
    .en_i   (irq_en_i),
    .call_i (call_i),
    .ret_i  (ret_i),
    .full_i (full_o),
    .take_o (take),
    .ack_o  (irq_ack_o)
  );

  rstk_ctrl #(.DEPTH(DEPTH), .PW(PW), .LW(LW)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .push_i    (call_i | take),
    .pop_i     (ret_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .full_o    (full_o),
    .ovf_o     (ovf_o),
    .udf_o     (udf_o)
  );

  rstk_ram #(.DEPTH(DEPTH), .AW(PW), .DW(PC_W)) u_ram (
    .clk     (clk),
    .rst     (rst),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (pc_i),
    .re_i    (rd_en),
    .raddr_i (rd_addr),
    .rdata_o (ret_pc_o)
  );

  assert_ack_not_full_R6: assert property (@(posedge clk) disable iff (rst)
    irq_ack_o |-> $past(!full_o));
  assert_call_wins_R9: assert property (@(posedge clk) disable iff (rst)
    call_i |=> !irq_ack_o);

endmodule

// File: tb/sim_pc_retstack.sv
module sim_pc_retstack;

  localparam int PC_W = 13;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            call_i = 1'b0, ret_i = 1'b0, irq_req_i = 1'b0, irq_en_i = 1'b0;
  logic [PC_W-1:0] pc_i = '0;
  logic [PC_W-1:0] ret_pc_o;
  logic            irq_ack_o, full_o, ovf_o, udf_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  pc_retstack #(.DEPTH(16), .PC_W(PC_W)) u0 (
    .clk(clk), .rst(rst), .call_i(call_i), .ret_i(ret_i),
    .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .pc_i(pc_i),
    .ret_pc_o(ret_pc_o), .irq_ack_o(irq_ack_o), .full_o(full_o),
    .ovf_o(ovf_o), .udf_o(udf_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    call_i = 0; ret_i = 0; irq_req_i = 0; irq_en_i = 0; pc_i = '0;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic do_call(input logic [PC_W-1:0] pc);
    pc_i = pc; call_i = 1;
    @(negedge clk);
    call_i = 0;
  endtask

  task automatic do_ret(input string req, input logic [PC_W-1:0] exp);
    ret_i = 1;
    @(negedge clk);
    ret_i = 0;
    chk(req, "ret_pc_o", 32'(ret_pc_o), 32'(exp));
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "ret_pc_o", 32'(ret_pc_o), 0);
    chk("R1", "irq_ack_o", 32'(irq_ack_o), 0);
    chk("R1", "full_o", 32'(full_o), 0);
    chk("R1", "ovf_o", 32'(ovf_o), 0);
    chk("R1", "udf_o", 32'(udf_o), 0);
  endtask

  task automatic t_lifo();
    do_reset();
    do_call(13'h0A1);
    do_call(13'h1B2);
    do_call(13'h0C3);
    do_ret("R2", 13'h0C3);
    do_call(13'h1D4);
    do_ret("R2", 13'h1D4);
    do_ret("R2", 13'h1B2);
    do_ret("R2", 13'h0A1);
    chk("R2", "udf_o", 32'(udf_o), 0);
  endtask

  task automatic t_irq_basic();
    do_reset();
    irq_en_i = 1; pc_i = 13'h0AA; irq_req_i = 1;
    @(negedge clk);
    irq_req_i = 0;
    chk("R3", "ack one cycle after request", 32'(irq_ack_o), 0);
    @(negedge clk);
    chk("R3", "ack two cycles after request", 32'(irq_ack_o), 1);
    @(negedge clk);
    chk("R3", "ack single pulse", 32'(irq_ack_o), 0);
    do_ret("R3", 13'h0AA);
  endtask

  task automatic t_irq_disabled();
    do_reset();
    irq_en_i = 0; irq_req_i = 1;
    @(negedge clk);
    irq_req_i = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4", "ack with enable low", 32'(irq_ack_o), 0);
    end
    irq_en_i = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4", "ack after late enable", 32'(irq_ack_o), 0);
    end
    do_call(13'h055);
    do_ret("R4", 13'h055);
    chk("R4", "nothing stacked (udf_o)", 32'(udf_o), 0);
  endtask

  task automatic t_full_hold();
    do_reset();
    for (int i = 0; i < 16; i++) begin
      chk("R5", "full_o before fill", 32'(full_o), 0);
      do_call(PC_W'(13'h200 + i));
    end
    chk("R5", "full_o at 16", 32'(full_o), 1);
    irq_en_i = 1; pc_i = 13'h3CC; irq_req_i = 1;
    @(negedge clk);
    irq_req_i = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6", "ack while full", 32'(irq_ack_o), 0);
    end
    do_ret("R6", 13'h20F);
    chk("R6", "ack in return cycle", 32'(irq_ack_o), 0);
    chk("R5", "full_o after return", 32'(full_o), 0);
    @(negedge clk);
    chk("R6", "ack after return", 32'(irq_ack_o), 1);
    chk("R6", "full_o after ack", 32'(full_o), 1);
    do_ret("R6", 13'h3CC);
    do_ret("R6", 13'h20E);
    chk("R7", "ovf_o without overflow", 32'(ovf_o), 0);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < 16; i++) do_call(PC_W'(13'h100 + i));
    chk("R7", "ovf_o at exactly full", 32'(ovf_o), 0);
    do_call(13'h110);
    chk("R7", "ovf_o after extra call", 32'(ovf_o), 1);
    chk("R7", "full_o after extra call", 32'(full_o), 1);
    for (int j = 0; j < 16; j++) do_ret("R7", PC_W'(13'h110 - j));
    chk("R7", "ovf_o sticky", 32'(ovf_o), 1);
    chk("R5", "full_o drained", 32'(full_o), 0);
    do_ret("R8", 13'h101);
    chk("R8", "udf_o after empty pop", 32'(udf_o), 1);
  endtask

  task automatic t_underflow();
    do_reset();
    do_call(13'h077);
    do_ret("R8", 13'h077);
    chk("R8", "udf_o before empty pop", 32'(udf_o), 0);
    do_ret("R8", 13'h077);
    chk("R8", "udf_o set", 32'(udf_o), 1);
    do_call(13'h088);
    do_ret("R8", 13'h088);
    chk("R8", "udf_o sticky", 32'(udf_o), 1);
  endtask

  task automatic t_call_vs_irq();
    do_reset();
    irq_en_i = 1; pc_i = 13'h111; irq_req_i = 1;
    @(negedge clk);
    irq_req_i = 0;
    do_call(13'h122);
    chk("R9", "ack deferred by call", 32'(irq_ack_o), 0);
    pc_i = 13'h133;
    @(negedge clk);
    chk("R9", "ack one cycle later", 32'(irq_ack_o), 1);
    do_ret("R9", 13'h133);
    do_ret("R9", 13'h122);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_lifo();
    t_irq_basic();
    t_irq_disabled();
    t_full_hold();
    t_overflow();
    t_underflow();
    t_call_vs_irq();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule